// File: doc/BRIEF.md
# Floating-Point Compare to Condition Code

This block compares two IEEE-754 operands, either both single precision or both double precision, and reports how they are ordered as a 2-bit condition code. The code is also placed into a 32-bit status word. A start strobe captures the operands, the precision select, the quiet/signaling select and the incoming status word. One cycle later the block raises `done` for one cycle. In that same cycle the condition code, the invalid-operation flag and the updated status word are valid.

Two compare flavours are provided. The quiet compare flags invalid only when a signaling NaN takes part. The signaling compare flags invalid whenever the result is unordered. When single precision is selected, each operand is the low 32 bits of its input and the upper 32 bits are ignored. The results hold until the next start.

The controller is a two-state machine:
- `ST_IDLE`: no result is being presented.
- `ST_DONE`: a result is presented and `done` is high.

Its transitions are:
- `ST_IDLE -> ST_DONE` on start.
- `ST_DONE -> ST_DONE` on a back-to-back start.
- `ST_DONE -> ST_IDLE` when no start arrives.

Top module: `fp_compare_cc`

## Requirements
- R1: While reset is asserted, and after it is released, `done`, `invalid`, `cc_out` and `status_out` are 0 until the first start.
- R2: `done` is high in exactly the cycle after each cycle in which `start` is high, and low otherwise.
- R3: Equal operands give code 0. Positive zero and negative zero compare equal.
- R4: An ordered result gives code 1 when `op_a` is below `op_b` and code 2 when it is above. The ordering is by sign and magnitude and includes infinities and negative values.
- R5: A NaN in either operand gives code 3 (unordered). A NaN has an all-ones exponent and a nonzero fraction.
- R6: For a quiet compare (`sig_sel`=0), `invalid` is 1 only if an operand is a signaling NaN. A NaN is signaling when the top fraction bit is 0.
- R7: For a signaling compare (`sig_sel`=1), `invalid` is 1 for every unordered result.
- R8: `status_out[11:10]` holds the code. Every other bit of `status_out` equals `status_in` as sampled at start.
- R9: With `dbl_sel`=0, only bits 31:0 of each operand are compared as single precision. With `dbl_sel`=1, all 64 bits are compared as double precision.
- R10: `invalid` is never 1 together with an ordered code.
- R11: `cc_out`, `invalid` and `status_out` keep their values in cycles with no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture operands and begin a compare |
| dbl_sel | input | 1 | 1 = double precision, 0 = single precision (low 32 bits) |
| sig_sel | input | 1 | 1 = signaling compare, 0 = quiet compare |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| status_in | input | 32 | Status word whose code field is replaced |
| status_out | output | 32 | Status word with code at bits 11:10 |
| cc_out | output | 2 | Condition code: 0 eq, 1 less, 2 greater, 3 unordered |
| invalid | output | 1 | Invalid-operation flag for this compare |
| done | output | 1 | Result valid, one cycle after start |

## Verification
Two events can coincide in one cycle. A result is presented in the `ST_DONE` state while a new start captures the next compare. The bench provokes this by issuing compares on consecutive cycles. Its scoreboard queues one expected item per start and pops exactly one per `done` cycle, so a result that is dropped, repeated or mixed with its successor shows up as a mismatch in code, flag or status word.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_W      = SP_EXP_W + SP_FRAC_W + 1;
    localparam int DP_W      = DP_EXP_W + DP_FRAC_W + 1;
    localparam int MAG_W     = DP_W - 1;

    typedef enum logic [1:0] {
        CC_EQ = 2'd0,
        CC_LT = 2'd1,
        CC_GT = 2'd2,
        CC_UN = 2'd3
    } cc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } state_e;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             snan;
        logic             zero;
        logic [MAG_W-1:0] mag;
    } opnd_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] raw,
    output opnd_t                 info
);
    localparam int W = EXP_W + FRAC_W + 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f     = raw[W-2:FRAC_W];
        frac_f    = raw[FRAC_W-1:0];
        info.sign = raw[W-1];
        info.nan  = (&exp_f) && (|frac_f);
        info.snan = info.nan && !frac_f[FRAC_W-1];
        info.zero = ~|raw[W-2:0];
        info.mag  = MAG_W'(raw[W-2:0]);
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  opnd_t a,
    input  opnd_t b,
    output cc_e   cc
);
    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = a.mag < b.mag;
        mag_eq = a.mag == b.mag;
        if (a.nan || b.nan)
            cc = CC_UN;
        else if (a.zero && b.zero)
            cc = CC_EQ;
        else if (a.sign != b.sign)
            cc = a.sign ? CC_LT : CC_GT;
        else if (mag_eq)
            cc = CC_EQ;
        else
            cc = (mag_lt ^ a.sign) ? CC_LT : CC_GT;
    end
endmodule

// File: rtl/fpcmp_ctrl.sv
module fpcmp_ctrl
    import fpcmp_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int CC_LSB = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cc_e               cc_next,
    input  logic              inv_next,
    input  logic [STAT_W-1:0] status_in,
    output cc_e               cc_q,
    output logic              inv_q,
    output logic [STAT_W-1:0] status_q,
    output logic              done
);
    localparam logic [STAT_W-1:0] CC_MASK = STAT_W'(2'b11) << CC_LSB;

    state_e            state;
    state_e            state_nxt;
    logic [STAT_W-1:0] merged;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start) state_nxt = ST_DONE;
            ST_DONE: state_nxt = start ? ST_DONE : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        merged = (status_in & ~CC_MASK) | (STAT_W'(cc_next) << CC_LSB);
        done   = (state == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q     <= CC_EQ;
            inv_q    <= 1'b0;
            status_q <= '0;
        end else if (start) begin
            cc_q     <= cc_next;
            inv_q    <= inv_next;
            status_q <= merged;
        end
    end

    // R2: done follows start by one cycle
    p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    // R11: results hold when idle
    p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(cc_q) && $stable(inv_q) && $stable(status_q)));
    // R8: only the code field changes in the status word
    p_status_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ((status_q & ~CC_MASK) == ($past(status_in) & ~CC_MASK)));
endmodule

// File: rtl/fp_compare_cc.sv
module fp_compare_cc
    import fpcmp_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int CC_LSB = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dbl_sel,
    input  logic              sig_sel,
    input  logic [DP_W-1:0]   op_a,
    input  logic [DP_W-1:0]   op_b,
    input  logic [STAT_W-1:0] status_in,
    output logic [STAT_W-1:0] status_out,
    output logic [1:0]        cc_out,
    output logic              invalid,
    output logic              done
);
    localparam int N_OPS = 2;

    logic [DP_W-1:0] ops [N_OPS];
    opnd_t           sp_info [N_OPS];
    opnd_t           dp_info [N_OPS];
    opnd_t           sel_info [N_OPS];
    cc_e             cc_next;
    cc_e             cc_q;
    logic            inv_next;
    logic            snan_any;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < N_OPS; i++) begin : g_opnd
        fpcmp_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
            .raw  (ops[i][SP_W-1:0]),
            .info (sp_info[i])
        );
        fpcmp_classify #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
            .raw  (ops[i]),
            .info (dp_info[i])
        );
        assign sel_info[i] = dbl_sel ? dp_info[i] : sp_info[i];
    end

    fpcmp_order u_order (
        .a  (sel_info[0]),
        .b  (sel_info[1]),
        .cc (cc_next)
    );

    always_comb begin
        snan_any = sel_info[0].snan || sel_info[1].snan;
        inv_next = (cc_next == CC_UN) && (sig_sel || snan_any);
    end

    fpcmp_ctrl #(.STAT_W(STAT_W), .CC_LSB(CC_LSB)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cc_next   (cc_next),
        .inv_next  (inv_next),
        .status_in (status_in),
        .cc_q      (cc_q),
        .inv_q     (invalid),
        .status_q  (status_out),
        .done      (done)
    );

    assign cc_out = cc_q;

    // R10: invalid only with an unordered code
    p_inv_unordered_r10: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> (cc_out == 2'd3));
    // R7: signaling compare flags every unordered result
    p_signaling_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && sig_sel && (sel_info[0].nan || sel_info[1].nan)) |=> invalid);
    // R6: quiet compare without a signaling NaN stays clear
    p_quiet_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !sig_sel && !snan_any) |=> !invalid);
    // R8: code field of the status word mirrors the code output
    p_status_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status_out[CC_LSB+1:CC_LSB] == cc_out));
endmodule

// File: tb/fp_compare_cc_bench.sv
module fp_compare_cc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dbl_sel = 1'b0;
    logic        sig_sel = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [31:0] status_in = '0;
    logic [31:0] status_out;
    logic [1:0]  cc_out;
    logic        invalid;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [1:0]  cc;
        logic        inv;
        logic [31:0] stat;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    fp_compare_cc u_fp_compare_cc (
        .clk(clk), .rst_n(rst_n), .start(start), .dbl_sel(dbl_sel),
        .sig_sel(sig_sel), .op_a(op_a), .op_b(op_b), .status_in(status_in),
        .status_out(status_out), .cc_out(cc_out), .invalid(invalid), .done(done)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one start per call; expected values come from the requirements
    task automatic issue(input bit dbl, input bit sig, input logic [63:0] a,
                         input logic [63:0] b, input logic [31:0] st,
                         input logic [1:0] cc, input bit inv, input string tag);
        exp_t e;
        @(negedge clk);
        start = 1'b1; dbl_sel = dbl; sig_sel = sig;
        op_a = a; op_b = b; status_in = st;
        e.cc = cc; e.inv = inv; e.stat = (st & ~32'h0000_0C00) | (32'(cc) << 10); e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        start = 1'b0;
        op_a = 64'hDEAD_BEEF_0BAD_F00D; op_b = 64'h7FF8_0000_0000_0000;
        status_in = 32'hFFFF_FFFF; sig_sel = 1'b1;
    endtask

    // Monitor: pops one expected item for every done cycle
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2 done without start", 64'(done), 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(cc_out == e.cc, {e.tag, " cc"}, 64'(cc_out), 64'(e.cc));
                check(invalid == e.inv, {e.tag, " invalid"}, 64'(invalid), 64'(e.inv));
                check(status_out == e.stat, {e.tag, " R8 status"}, 64'(status_out), 64'(e.stat));
            end
        end
    end

    localparam logic [63:0] S1P = 64'h0000_0000_3F80_0000, S2P = 64'h0000_0000_4000_0000;
    localparam logic [63:0] S1N = 64'h0000_0000_BF80_0000, S2N = 64'h0000_0000_C000_0000;
    localparam logic [63:0] SZN = 64'h0000_0000_8000_0000, SINF = 64'h0000_0000_7F80_0000;
    localparam logic [63:0] SQN = 64'h0000_0000_7FC0_0000, SSN = 64'h0000_0000_7F80_0001;
    localparam logic [63:0] D1P = 64'h3FF0_0000_0000_0000, D2P = 64'h4000_0000_0000_0000;
    localparam logic [63:0] D1N = 64'hBFF0_0000_0000_0000, D2N = 64'hC000_0000_0000_0000;
    localparam logic [63:0] DZN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] DQN = 64'h7FF8_0000_0000_0000, DSN = 64'h7FF0_0000_0000_0001;
    localparam logic [31:0] ST  = 32'hA5A5_0C5A;

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0 && invalid == 1'b0 && cc_out == 2'd0 && status_out == 32'd0,
              "R1 reset state", {cc_out, invalid, done, status_out}, 64'd0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && status_out == 32'd0, "R1 after release", 64'(status_out), 64'd0);

        // single precision, back-to-back starts
        issue(0, 0, S1P, S1P, ST, 2'd0, 0, "R3 sp equal");
        issue(0, 0, 64'd0, SZN, ST, 2'd0, 0, "R3 sp +0/-0");
        issue(0, 0, S1P, S2P, ST, 2'd1, 0, "R4 sp less");
        issue(0, 0, S1N, S2N, ST, 2'd2, 0, "R4 sp negatives");
        issue(0, 0, S2N, S1P, ST, 2'd1, 0, "R4 sp mixed sign");
        issue(0, 1, SINF, S2P, ST, 2'd2, 0, "R4 R10 sp infinity");
        issue(0, 0, SQN, S1P, ST, 2'd3, 0, "R5 R6 sp quiet qnan");
        issue(0, 1, SQN, S1P, ST, 2'd3, 1, "R7 sp signaling qnan");
        issue(0, 0, S1P, SSN, ST, 2'd3, 1, "R6 sp quiet snan");
        issue(0, 0, {32'hFFFF_FFFF, S1P[31:0]}, S1P, 32'h0000_0000, 2'd0, 0, "R9 sp upper ignored");
        idle();
        idle();
        check(done == 1'b0 && cc_out == 2'd0 && invalid == 1'b0, "R11 hold idle",
              {cc_out, invalid, done}, 64'd0);
        check(status_out == 32'h0000_0000, "R11 status hold", 64'(status_out), 64'd0);

        // precision select: same bits read two ways
        issue(0, 0, D1P, S1P, ST, 2'd1, 0, "R9 sp view");
        issue(1, 0, D1P, S1P, ST, 2'd2, 0, "R9 dp view");

        // double precision
        issue(1, 0, D1P, D2P, 32'hFFFF_FFFF, 2'd1, 0, "R4 dp less");
        issue(1, 0, D1N, D2N, ST, 2'd2, 0, "R4 dp negatives");
        issue(1, 0, DZN, 64'd0, ST, 2'd0, 0, "R3 dp -0/+0");
        issue(1, 1, D2P, D2P, ST, 2'd0, 0, "R10 dp signaling equal");
        issue(1, 0, DQN, D1P, ST, 2'd3, 0, "R6 dp quiet qnan");
        issue(1, 0, D1P, DSN, ST, 2'd3, 1, "R6 dp quiet snan");
        issue(1, 1, DQN, DQN, 32'h0000_0000, 2'd3, 1, "R7 dp signaling");
        idle();
        idle();
        check(done == 1'b0 && cc_out == 2'd3 && invalid == 1'b1, "R11 hold after dp",
              {cc_out, invalid, done}, {2'd3, 1'b1, 1'b0});
        check(sb_q.size() == 0, "R2 all results seen", 64'(sb_q.size()), 64'd0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule